// File: doc/BRIEF.md
# Folded 64-bit Add-Rotate-Xor Mixer

This block performs the add-rotate-xor mixing step on a pair of 64-bit words while spending only one 32-bit adder on it. A request names the two operand words by their index in an external memory that is organised as 32-bit halves. The request also carries an operation select and a 6-bit rotate count. The unit fetches both low halves in one cycle and both high halves in the next. It adds the low halves, keeps the carry in a register and adds the high halves with that carry. The complete second operand then passes through a barrel rotator that has a single register stage.

Two operations share the datapath. A mix returns `A + B` and `rotl(B, r) ^ (A + B)`. A key-injection add returns `A + B` and passes `B` through unchanged, with no rotation or xor. The unit takes one request at a time. It holds both results in output registers and flags them with a one-cycle done pulse. The caller owns round sequencing, constants, the rotate schedule and where results are written back.

Top module: `arx_mix_unit`

## Requirements
- R1: For either operation, `res_a` equals the sum of operand word A and operand word B modulo 2^64.
- R2: With `req_op` = 0 (mix), `res_b` equals operand B rotated left by the requested count, xored with the new `res_a`.
- R3: The carry out of bit 31 of the sum reaches the upper half: 0x00000000_FFFFFFFF + 1 gives 0x00000001_00000000, and all-ones + 1 gives zero.
- R4: With `req_op` = 1 (key add), `res_b` equals operand B unchanged, whatever rotate count was given.
- R5: Every rotate count from 0 to 63 is honoured. The count is captured with the request, and changes on `req_rot` after acceptance have no effect.
- R6: A half address is `{word_index, half}`, with bit 0 = 0 for bits 31:0 and 1 for bits 63:32. In the cycle after acceptance both read ports present the low-half addresses of A (port x) and B (port y). In the following cycle they present the high-half addresses. Read data returns one cycle after its address.
- R7: A request is accepted at a clock edge where `req_valid` is high and `busy` is low. `busy` is high from the next cycle until `done` rises. `done` is high for exactly one cycle, starting after the fourth edge following acceptance.
- R8: A request raised while `busy` is high is ignored: the running operation's results are unchanged, and no extra done pulse follows.
- R9: After reset, `done` and `busy` are low and both results are zero.
- R10: `res_a` and `res_b` hold their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_op | input | 1 | 0 = mix, 1 = key-injection add |
| req_rot | input | 6 | Left-rotate count for the mix |
| req_addr_a | input | 4 | Word index of operand A |
| req_addr_b | input | 4 | Word index of operand B |
| busy | output | 1 | Operation in progress |
| rd_addr_x | output | 5 | Half address for operand A reads |
| rd_addr_y | output | 5 | Half address for operand B reads |
| rd_data_x | input | 32 | Read data for port x, one cycle after its address |
| rd_data_y | input | 32 | Read data for port y, one cycle after its address |
| res_a | output | 64 | Sum result |
| res_b | output | 64 | Mixed or passed-through second word |
| done | output | 1 | One-cycle pulse when results are valid |

## Verification
The bench targets sums that carry out of bit 31. A design that dropped or delayed the stored carry would return an upper half that is one too low. It also runs the rotate counts 0 and 63, where a rotator stage wired to the wrong shift would wrap bits to the wrong places. Key adds are given nonzero rotate counts, so a design that did not bypass the rotator would corrupt `res_b`. Requests are also raised mid-operation while `req_rot` changes underneath, which exposes a unit that restarts, re-samples the count or emits a second done pulse.

// File: rtl/arx_pkg.sv
package arx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_LO  = 3'd1,
    ST_RD_HI  = 3'd2,
    ST_ADD_HI = 3'd3,
    ST_FIN    = 3'd4
  } arx_state_t;

  typedef enum logic {
    OP_MIX = 1'b0,
    OP_KEY = 1'b1
  } arx_op_t;
endpackage

// File: rtl/arx_half_adder.sv
module arx_half_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, cin};
    sum  = wide[W-1:0];
    cout = wide[W];
  end
endmodule

// File: rtl/arx_rot_pipe.sv
module arx_rot_pipe #(
  parameter int W     = 64,
  parameter int ROT_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [W-1:0]     din,
  input  logic [ROT_W-1:0] amt,
  output logic [W-1:0]     dout
);
  logic [W-1:0] stg [0:ROT_W];

  assign stg[0] = din;

  // One stage per count bit: stage i rotates left by 2**i when selected.
  generate
    for (genvar i = 0; i < ROT_W; i++) begin : g_stage
      localparam int SH = 1 << i;
      assign stg[i+1] = amt[i] ? {stg[i][W-1-SH:0], stg[i][W-1:W-SH]} : stg[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (en) begin
      dout <= stg[ROT_W];
    end
  end
endmodule

// File: rtl/arx_ctrl.sv
module arx_ctrl
  import arx_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int ROT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_op,
  input  logic [ROT_W-1:0]  req_rot,
  input  logic [ADDR_W-1:0] req_addr_a,
  input  logic [ADDR_W-1:0] req_addr_b,
  output arx_state_t        state,
  output arx_op_t           op_q,
  output logic [ROT_W-1:0]  rot_q,
  output logic [ADDR_W:0]   rd_addr_x,
  output logic [ADDR_W:0]   rd_addr_y,
  output logic              busy
);
  logic [ADDR_W-1:0] idx_a_q;
  logic [ADDR_W-1:0] idx_b_q;
  arx_state_t        nxt;
  logic              accept;

  assign accept = req_valid && (state == ST_IDLE);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (accept) nxt = ST_RD_LO;
      ST_RD_LO:  nxt = ST_RD_HI;
      ST_RD_HI:  nxt = ST_ADD_HI;
      ST_ADD_HI: nxt = ST_FIN;
      ST_FIN:    nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      op_q    <= OP_MIX;
      rot_q   <= '0;
      idx_a_q <= '0;
      idx_b_q <= '0;
    end else begin
      state <= nxt;
      if (accept) begin
        op_q    <= arx_op_t'(req_op);
        rot_q   <= req_rot;
        idx_a_q <= req_addr_a;
        idx_b_q <= req_addr_b;
      end
    end
  end

  logic half_sel;
  assign half_sel  = (state == ST_RD_HI);
  assign rd_addr_x = {idx_a_q, half_sel};
  assign rd_addr_y = {idx_b_q, half_sel};
  assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/arx_mix_unit.sv
module arx_mix_unit
  import arx_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int ADDR_W = 4,
  localparam int HALF_W = WORD_W / 2,
  localparam int ROT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_op,
  input  logic [ROT_W-1:0]  req_rot,
  input  logic [ADDR_W-1:0] req_addr_a,
  input  logic [ADDR_W-1:0] req_addr_b,
  output logic              busy,
  output logic [ADDR_W:0]   rd_addr_x,
  output logic [ADDR_W:0]   rd_addr_y,
  input  logic [HALF_W-1:0] rd_data_x,
  input  logic [HALF_W-1:0] rd_data_y,
  output logic [WORD_W-1:0] res_a,
  output logic [WORD_W-1:0] res_b,
  output logic              done
);
  arx_state_t        state;
  arx_op_t           op_q;
  logic [ROT_W-1:0]  rot_q;

  arx_ctrl #(.ADDR_W(ADDR_W), .ROT_W(ROT_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_op(req_op), .req_rot(req_rot),
    .req_addr_a(req_addr_a), .req_addr_b(req_addr_b),
    .state(state), .op_q(op_q), .rot_q(rot_q),
    .rd_addr_x(rd_addr_x), .rd_addr_y(rd_addr_y), .busy(busy)
  );

  // Shared adder: low halves in ST_RD_HI, high halves plus stored carry in ST_ADD_HI.
  logic [HALF_W-1:0] add_sum;
  logic              add_cout;
  logic              add_cin;
  logic              carry_q;
  logic [HALF_W-1:0] sum_lo_q;
  logic [HALF_W-1:0] sum_hi_q;
  logic [HALF_W-1:0] b_lo_q;

  assign add_cin = (state == ST_ADD_HI) ? carry_q : 1'b0;

  arx_half_adder #(.W(HALF_W)) u_add (
    .op_a(rd_data_x), .op_b(rd_data_y), .cin(add_cin),
    .sum(add_sum), .cout(add_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q  <= 1'b0;
      sum_lo_q <= '0;
      sum_hi_q <= '0;
      b_lo_q   <= '0;
    end else begin
      if (state == ST_RD_HI) begin
        sum_lo_q <= add_sum;
        carry_q  <= add_cout;
        b_lo_q   <= rd_data_y;
      end
      if (state == ST_ADD_HI) begin
        sum_hi_q <= add_sum;
      end
    end
  end

  // Rotator: key add forces a zero count so the word passes unchanged.
  logic [WORD_W-1:0] rot_out;
  logic [ROT_W-1:0]  rot_amt;
  assign rot_amt = (op_q == OP_KEY) ? '0 : rot_q;

  arx_rot_pipe #(.W(WORD_W), .ROT_W(ROT_W)) u_rot (
    .clk(clk), .rst(rst), .en(state == ST_ADD_HI),
    .din({rd_data_y, b_lo_q}), .amt(rot_amt), .dout(rot_out)
  );

  logic [WORD_W-1:0] sum_full;
  assign sum_full = {sum_hi_q, sum_lo_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      res_a <= '0;
      res_b <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_FIN) begin
        res_a <= sum_full;
        res_b <= (op_q == OP_MIX) ? (rot_out ^ sum_full) : rot_out;
        done  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/arx_mix_chk.sv
module arx_mix_chk #(
  parameter int WORD_W = 64,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W:0]   rd_addr_x,
  input logic [ADDR_W:0]   rd_addr_y,
  input logic [WORD_W-1:0] res_a,
  input logic [WORD_W-1:0] res_b
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R7

  AST_LOW_FIRST: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> (!rd_addr_x[0] && !rd_addr_y[0])); // R6

  AST_HIGH_NEXT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> ##1 (rd_addr_x[0] && rd_addr_y[0])); // R6

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(res_a) && $stable(res_b))); // R10
endmodule

bind arx_mix_unit arx_mix_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy), .done(done),
  .rd_addr_x(rd_addr_x), .rd_addr_y(rd_addr_y), .res_a(res_a), .res_b(res_b)
);

// File: tb/sim_arx_mix_unit.sv
module sim_arx_mix_unit;
  localparam int AW = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_op;
  logic [5:0]  req_rot;
  logic [AW-1:0] req_addr_a, req_addr_b;
  logic        busy, done;
  logic [AW:0] rd_addr_x, rd_addr_y;
  logic [31:0] rd_data_x, rd_data_y;
  logic [63:0] res_a, res_b;

  logic [31:0] mem [0:(1<<(AW+1))-1];

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    rd_data_x <= mem[rd_addr_x];
    rd_data_y <= mem[rd_addr_y];
  end

  arx_mix_unit #(.WORD_W(64), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_rot(req_rot), .req_addr_a(req_addr_a), .req_addr_b(req_addr_b),
    .busy(busy), .rd_addr_x(rd_addr_x), .rd_addr_y(rd_addr_y),
    .rd_data_x(rd_data_x), .rd_data_y(rd_data_y),
    .res_a(res_a), .res_b(res_b), .done(done)
  );

  function automatic logic [63:0] rotl(input logic [63:0] x, input int r);
    if (r == 0) return x;
    return (x << r) | (x >> (64 - r));
  endfunction

  function automatic logic [63:0] word_of(input int idx);
    return {mem[2*idx+1], mem[2*idx]};
  endfunction

  task automatic put_word(input int idx, input logic [63:0] v);
    mem[2*idx]   = v[31:0];
    mem[2*idx+1] = v[63:32];
  endtask

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic op, input int rot, input int ia, input int ib, input logic poke);
    logic [63:0] a, b, ea, eb;
    a  = word_of(ia);
    b  = word_of(ib);
    ea = a + b;
    eb = op ? b : (rotl(b, rot) ^ ea);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_rot = 6'(rot);
    req_addr_a = AW'(ia); req_addr_b = AW'(ib);
    @(negedge clk);
    // R5: disturb the count after acceptance
    req_valid = poke; req_op = ~op; req_rot = ~6'(rot);
    req_addr_a = AW'($urandom); req_addr_b = AW'($urandom);
    chk(busy == 1'b1, "R7 busy after accept", 64'(busy), 64'd1);
    chk(rd_addr_x == {AW'(ia), 1'b0} && rd_addr_y == {AW'(ib), 1'b0},
        "R6 low half addresses", {rd_addr_x, rd_addr_y}, {AW'(ia), 1'b0, AW'(ib), 1'b0});
    @(negedge clk);
    chk(rd_addr_x == {AW'(ia), 1'b1} && rd_addr_y == {AW'(ib), 1'b1},
        "R6 high half addresses", {rd_addr_x, rd_addr_y}, {AW'(ia), 1'b1, AW'(ib), 1'b1});
    @(negedge clk);
    chk(done == 1'b0, "R7 no early done", 64'(done), 64'd0);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R7 done after four edges", {busy, done}, 64'b01);
    chk(res_a == ea, "R1/R3 sum word", res_a, ea);
    chk(res_b == eb, op ? "R4 key add passes B" : "R2/R5 mixed word", res_b, eb);
    @(negedge clk);
    chk(done == 1'b0, "R8 single done pulse", 64'(done), 64'd0);
    chk(res_a == ea && res_b == eb, "R10 results held", res_a ^ res_b, ea ^ eb);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < (1 << AW); i++) put_word(i, {$urandom, $urandom});
    rst = 1'b1; req_valid = 1'b0; req_op = 1'b0; req_rot = '0;
    req_addr_a = '0; req_addr_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(done == 1'b0 && busy == 1'b0, "R9 reset flags", {busy, done}, 64'd0);
    chk(res_a == 64'd0 && res_b == 64'd0, "R9 reset results", res_a | res_b, 64'd0);

    // R3: carry across the half boundary and full wrap
    put_word(1, 64'h00000000_FFFFFFFF); put_word(2, 64'd1);
    run_op(1'b0, 5, 1, 2, 1'b0);
    put_word(3, 64'hFFFFFFFF_FFFFFFFF);
    run_op(1'b0, 17, 3, 2, 1'b0);
    // R5: extreme counts
    put_word(4, 64'h80000000_00000001); put_word(5, 64'h0123456789ABCDEF);
    run_op(1'b0, 0, 5, 4, 1'b0);
    run_op(1'b0, 63, 5, 4, 1'b0);
    run_op(1'b0, 32, 4, 5, 1'b0);
    // R4: key add with nonzero count, R8 poke while busy
    run_op(1'b1, 41, 5, 4, 1'b1);
    run_op(1'b0, 9, 3, 3, 1'b1);
    run_op(1'b0, 13, 6, 6, 1'b0);

    for (int n = 0; n < 60; n++) begin
      run_op(1'($urandom), int'($urandom_range(0, 63)),
             int'($urandom_range(0, (1 << AW) - 1)),
             int'($urandom_range(0, (1 << AW) - 1)), 1'($urandom));
      if (n % 10 == 0) put_word(int'($urandom_range(0, (1 << AW) - 1)), {$urandom, $urandom});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule